// File: doc/BRIEF.md
# Condition Flags and Predicate Unit

This block keeps the four processor status flags (negative, zero, carry, overflow) in a clocked register. For each issued instruction it does two things. It decides from the instruction's 4-bit condition code and the stored flags whether the instruction may execute. It also computes the new flag values from the ALU result, the adder carry and overflow, and the shifter carry-out.

The operation class controls which flags are written and when. Ordinary arithmetic and logical operations write flags only when the instruction asks for it. Compare-type operations (subtract-compare and add-compare) always write all four flags. Test-type operations (AND-test and XOR-test) always write negative and zero and leave carry and overflow as they were. An instruction whose condition fails changes no flag.

The predicate is combinational from the stored flags, so an instruction sees the flags written by the instructions before it and never its own update. A new flag value is visible from the cycle after the instruction that wrote it.

Top module: `cond_flag_unit`

## Requirements
- R1: While reset is high, the flags register clears to all zero (`flags` = 4'b0000). The bit order is N = bit 3, Z = bit 2, C = bit 1, V = bit 0.
- R2: The single-flag conditions evaluate as follows: code 0 passes when Z=1 and code 1 when Z=0; code 2 when C=1 and code 3 when C=0; code 4 when N=1 and code 5 when N=0; code 6 when V=1 and code 7 when V=0.
- R3: The compound conditions evaluate as follows. Code 8 passes when C=1 and Z=0; code 9 when C=0 or Z=1. Code 10 passes when N==V and code 11 when N!=V. Code 12 passes when Z=0 and N==V; code 13 when Z=1 or N!=V.
- R4: Codes 14 and 15 always pass. `exec_en` is low in any cycle where `valid` is low.
- R5: An executing arithmetic operation (class 0) with `set_flags` high writes N = result MSB, Z = (result == 0), C = `add_carry` and V = `add_ovf`.
- R6: An arithmetic or logical operation (class 0 or 1) with `set_flags` low leaves all four flags unchanged.
- R7: An executing compare operation (class 2) writes the flags as in R5, whatever the value of `set_flags`.
- R8: An executing logical operation (class 1) with `set_flags` high writes N and Z from the result, C = `shift_carry`, and keeps V.
- R9: An executing test operation (class 3) always writes N and Z from the result and keeps both C and V, whatever the values of `set_flags`, `add_carry` and `shift_carry`.
- R10: An instruction whose condition fails writes no flag, even when it is of compare or test class or has `set_flags` high.
- R11: A flag write becomes visible on `flags` in the cycle after the instruction. The instruction's own `exec_en` uses the flags from before its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | An instruction is issued this cycle |
| op_class | input | 2 | 0 arithmetic, 1 logical, 2 compare, 3 test |
| set_flags | input | 1 | The instruction requests a flag update |
| cond | input | 4 | Condition code (R2 to R4) |
| result | input | W | ALU result |
| add_carry | input | 1 | Adder carry-out |
| add_ovf | input | 1 | Adder signed overflow |
| shift_carry | input | 1 | Shifter carry-out |
| flags | output | 4 | Stored flags {N,Z,C,V} |
| exec_en | output | 1 | The instruction may execute |

## Verification
The assertions check on every cycle the following properties: reset clears the flags; idle cycles, failed predicates and requests without a flag update leave the flags unchanged; a test operation keeps carry and overflow and loads N and Z from the result; codes 14 and 15 always enable execution. The bench scenarios cover the full condition table for every reachable flag combination, the exact values written by each operation class, and the one-cycle visibility of a new flag value to the next instruction. They also show that a test operation ignores the carry inputs.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  typedef enum logic [1:0] {
    OPC_ARITH = 2'd0,
    OPC_LOGIC = 2'd1,
    OPC_CMP   = 2'd2,
    OPC_TEST  = 2'd3
  } op_class_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int unsigned COND_W     = 4;
  localparam int unsigned COND_PAIRS = 1 << (COND_W - 1);

endpackage

// File: rtl/cfu_predicate.sv
module cfu_predicate
  import cfu_pkg::*;
(
  input  nzcv_t             flags_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              pass_o
);

  // Each pair of codes shares one base test; the low code bit inverts it,
  // except in the last pair, where both codes always pass.
  logic [COND_PAIRS-1:0] base;
  logic                  sel_base;
  logic                  last_pair;

  genvar gi;
  generate
    for (gi = 0; gi < COND_PAIRS; gi++) begin : g_pair
      if (gi == 0) begin : g_zero
        assign base[gi] = flags_i.z;
      end else if (gi == 1) begin : g_carry
        assign base[gi] = flags_i.c;
      end else if (gi == 2) begin : g_neg
        assign base[gi] = flags_i.n;
      end else if (gi == 3) begin : g_ovf
        assign base[gi] = flags_i.v;
      end else if (gi == 4) begin : g_higher
        assign base[gi] = flags_i.c & ~flags_i.z;
      end else if (gi == 5) begin : g_ge
        assign base[gi] = ~(flags_i.n ^ flags_i.v);
      end else if (gi == 6) begin : g_gt
        assign base[gi] = ~flags_i.z & ~(flags_i.n ^ flags_i.v);
      end else begin : g_always
        assign base[gi] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    sel_base  = base[cond_i[COND_W-1:1]];
    last_pair = (cond_i[COND_W-1:1] == COND_W'(COND_PAIRS - 1));
    pass_o    = last_pair ? 1'b1 : (sel_base ^ cond_i[0]);
  end

endmodule

// File: rtl/cfu_flag_next.sv
module cfu_flag_next
  import cfu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  nzcv_t        cur_i,
  input  logic         exec_i,
  input  op_class_e    cls_i,
  input  logic         set_i,
  input  logic [W-1:0] result_i,
  input  logic         add_carry_i,
  input  logic         add_ovf_i,
  input  logic         shift_carry_i,
  output nzcv_t        nxt_o,
  output logic         we_o
);

  localparam int unsigned MSB = W - 1;

  logic res_neg;
  logic res_zero;
  logic always_upd;

  always_comb begin
    res_neg    = result_i[MSB];
    res_zero   = ~|result_i;
    always_upd = (cls_i == OPC_CMP) || (cls_i == OPC_TEST);
    we_o       = exec_i && (always_upd || set_i);

    nxt_o   = cur_i;
    nxt_o.n = res_neg;
    nxt_o.z = res_zero;
    unique case (cls_i)
      OPC_ARITH, OPC_CMP: begin
        nxt_o.c = add_carry_i;
        nxt_o.v = add_ovf_i;
      end
      OPC_LOGIC: begin
        nxt_o.c = shift_carry_i;
      end
      default: begin
        // test class: carry and overflow are kept
      end
    endcase
  end

endmodule

// File: rtl/cfu_flag_reg.sv
module cfu_flag_reg
  import cfu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  we_i,
  input  nzcv_t d_i,
  output nzcv_t q_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else if (we_i) begin
      q_o <= d_i;
    end
  end

endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic [1:0]   op_class,
  input  logic         set_flags,
  input  logic [3:0]   cond,
  input  logic [W-1:0] result,
  input  logic         add_carry,
  input  logic         add_ovf,
  input  logic         shift_carry,
  output logic [3:0]   flags,
  output logic         exec_en
);

  nzcv_t     cur_q;
  nzcv_t     nxt;
  logic      we;
  logic      pass;
  op_class_e cls;

  assign cls = op_class_e'(op_class);

  cfu_predicate u_pred (
    .flags_i (cur_q),
    .cond_i  (cond),
    .pass_o  (pass)
  );

  assign exec_en = valid & pass;

  cfu_flag_next #(.W(W)) u_next (
    .cur_i         (cur_q),
    .exec_i        (exec_en),
    .cls_i         (cls),
    .set_i         (set_flags),
    .result_i      (result),
    .add_carry_i   (add_carry),
    .add_ovf_i     (add_ovf),
    .shift_carry_i (shift_carry),
    .nxt_o         (nxt),
    .we_o          (we)
  );

  cfu_flag_reg u_reg (
    .clk  (clk),
    .rst  (rst),
    .we_i (we),
    .d_i  (nxt),
    .q_o  (cur_q)
  );

  assign flags = cur_q;

endmodule

// File: rtl/cfu_checker.sv
module cfu_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         valid,
  input logic [1:0]   op_class,
  input logic         set_flags,
  input logic [3:0]   cond,
  input logic [W-1:0] result,
  input logic [3:0]   flags,
  input logic         exec_en
);

  // R1: reset clears the flags
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> flags == 4'b0000);

  // R4: no execution without an issued instruction
  a_r4_idle_no_exec: assert property (@(posedge clk) disable iff (rst)
    !valid |-> !exec_en);

  // R4: codes 14 and 15 always pass
  a_r4_always_pass: assert property (@(posedge clk) disable iff (rst)
    (valid && cond[3:1] == 3'b111) |-> exec_en);

  // R6: no request and not a compare/test class, so the flags hold
  a_r6_no_request_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && !set_flags && !op_class[1]) |=> $stable(flags));

  // R10: a failed predicate writes nothing
  a_r10_false_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && !exec_en) |=> $stable(flags));

  // R9: a test op keeps C and V
  a_r9_test_keeps_cv: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_class == 2'd3) |=> $stable(flags[1:0]));

  // R9: a test op loads N and Z from the result
  a_r9_test_loads_nz: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_class == 2'd3) |=>
      (flags[3] == $past(result[W-1]) && flags[2] == ($past(result) == '0)));

  // R11: idle cycles leave the flags unchanged
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(flags));

endmodule

bind cond_flag_unit cfu_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid     (valid),
  .op_class  (op_class),
  .set_flags (set_flags),
  .cond      (cond),
  .result    (result),
  .flags     (flags),
  .exec_en   (exec_en)
);

// File: tb/sim_cond_flag_unit.sv
module sim_cond_flag_unit;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         valid = 1'b0;
  logic [1:0]   op_class = '0;
  logic         set_flags = 1'b0;
  logic [3:0]   cond = 4'd14;
  logic [W-1:0] result = '0;
  logic         add_carry = 1'b0;
  logic         add_ovf = 1'b0;
  logic         shift_carry = 1'b0;
  logic [3:0]   flags;
  logic         exec_en;

  always #5 clk = ~clk;

  cond_flag_unit #(.W(W)) u0 (
    .clk(clk), .rst(rst), .valid(valid), .op_class(op_class),
    .set_flags(set_flags), .cond(cond), .result(result),
    .add_carry(add_carry), .add_ovf(add_ovf), .shift_carry(shift_carry),
    .flags(flags), .exec_en(exec_en)
  );

  typedef struct {
    logic       exp_exec;
    logic [3:0] exp_flags;
    string      req;
  } item_t;

  item_t      sb[$];
  logic [3:0] mflags = 4'b0000;  // model {N,Z,C,V}
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  function automatic logic model_pass(input logic [3:0] f, input logic [3:0] c);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  // driver: applies one cycle of stimulus and queues the expectation
  task automatic issue(input logic v, input logic [1:0] cls, input logic sf,
                       input logic [3:0] c, input logic [W-1:0] res,
                       input logic ac, input logic ao, input logic sc,
                       input string req);
    item_t it;
    logic  ex;
    logic  upd;
    @(posedge clk);
    #2;
    valid = v; op_class = cls; set_flags = sf; cond = c; result = res;
    add_carry = ac; add_ovf = ao; shift_carry = sc;
    ex  = v && model_pass(mflags, c);
    it.exp_exec  = ex;
    it.exp_flags = mflags;
    it.req       = req;
    sb.push_back(it);
    upd = ex && (cls[1] || sf);
    if (upd) begin
      mflags[3] = res[W-1];
      mflags[2] = (res == '0);
      if (cls == 2'd0 || cls == 2'd2) begin
        mflags[1] = ac;
        mflags[0] = ao;
      end else if (cls == 2'd1) begin
        mflags[1] = sc;
      end
    end
  endtask

  task automatic idle(input string req);
    issue(1'b0, 2'd0, 1'b0, 4'd14, '0, 1'b0, 1'b0, 1'b0, req);
  endtask

  // loads arbitrary (N and Z not both set) flags through an arithmetic op
  task automatic load_flags(input logic [3:0] f, input string req);
    logic [W-1:0] r;
    r = f[3] ? {1'b1, {(W-1){1'b0}}} : (f[2] ? '0 : W'(1));
    issue(1'b1, 2'd0, 1'b1, 4'd14, r, f[1], f[0], 1'b0, req);
  endtask

  // monitor: compares outputs at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (exec_en !== it.exp_exec) begin
        n_fail++;
        $display("FAIL %s exec_en actual=%b expected=%b", it.req, exec_en, it.exp_exec);
      end
      n_chk++;
      if (flags !== it.exp_flags) begin
        n_fail++;
        $display("FAIL %s flags actual=%b expected=%b", it.req, flags, it.exp_flags);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        idle("R1");                                   // flags zero after reset
        // R5: arithmetic set, zero result with carry
        issue(1, 2'd0, 1, 4'd14, '0, 1, 0, 0, "R5");
        idle("R5");                                   // expect 0110
        // R6: no request, flags hold; R2 EQ passes
        issue(1, 2'd0, 0, 4'd0, 32'h8000_0000, 0, 1, 1, "R6");
        issue(1, 2'd1, 0, 4'd1, 32'h8000_0000, 0, 1, 1, "R6");
        idle("R6");
        // R8: logical set takes shifter carry, keeps V
        load_flags(4'b0001, "R8");
        issue(1, 2'd1, 1, 4'd14, 32'h8000_0000, 1, 0, 0, "R8");
        idle("R8");                                   // expect 1001
        // R7: compare writes without set_flags
        issue(1, 2'd2, 0, 4'd14, 32'h0000_0005, 1, 0, 0, "R7");
        idle("R7");                                   // expect 0010
        // R9: test keeps C and V, ignores carries
        load_flags(4'b1001, "R9");
        issue(1, 2'd3, 0, 4'd14, '0, 1, 0, 1, "R9");
        idle("R9");                                   // expect 0101
        // R10: failed predicate with set_flags and with compare class
        load_flags(4'b0000, "R10");
        issue(1, 2'd0, 1, 4'd0, 32'h8000_0000, 1, 1, 0, "R10");
        issue(1, 2'd2, 0, 4'd0, 32'h8000_0000, 1, 1, 0, "R10");
        issue(1, 2'd3, 1, 4'd0, 32'h8000_0000, 1, 1, 0, "R10");
        idle("R10");                                  // flags still 0000
        // R11: back-to-back dependency
        issue(1, 2'd0, 1, 4'd1, '0, 0, 0, 0, "R11"); // NE passes on old Z=0
        issue(1, 2'd0, 0, 4'd1, '0, 0, 0, 0, "R11"); // NE now fails, Z=1
        issue(1, 2'd0, 0, 4'd0, '0, 0, 0, 0, "R11"); // EQ passes
        // R2/R3/R4: full table over reachable flag states
        for (int f = 0; f < 16; f++) begin
          if (f[3] && f[2]) continue;
          load_flags(4'(f), "R5");
          for (int c = 0; c < 16; c++) begin
            issue(1, 2'd0, 0, 4'(c), 32'h1234_0000, 1, 1, 1,
                  (c < 8) ? "R2" : ((c < 14) ? "R3" : "R4"));
          end
          idle("R4");
        end
        // R1: reset in mid-run clears set flags
        load_flags(4'b1011, "R1");
        idle("R1");
        @(posedge clk); #2 rst = 1'b1;
        mflags = 4'b0000;
        @(posedge clk); #2 rst = 1'b0;
        idle("R1");
        idle("R4");
        @(posedge clk);
        @(posedge clk);
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_fail++;
          $display("FAIL watchdog actual=timeout expected=completion");
        end
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule